// File: doc/BRIEF.md
# Asynchronous Static RAM Behavioural Model (2K x 8)

This block models a 2048-byte static RAM with active-low select, output-enable and write-enable pins, so that such a memory can sit on an on-chip bus inside a synchronous design. The bidirectional byte lane is split into three signals: an input byte, an output byte and a drive-enable flag. Whatever wraps the block can then build a tri-state pad from them or merge them onto an internal multiplexed bus.

All pins are sampled on a fast system clock. A write is not clocked in at the sampling edge. It commits when write enable is seen going from low back to high while the chip was selected. The byte stored is the one present in the last sample that had write enable low. A read drives the port as soon as the sampled pins ask for it. The addressed byte appears only after a programmable number of clock cycles that stands in for the access time. Until then the lane carries zero.

Top module: `async_sram_2kx8`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `data_oe` is 0 and `data_out` is 0.
- R2: When a sample shows `we_n` high and the previous sample showed `cs_n` low and `we_n` low, the byte `data_in` from that previous sample is stored at the `addr` from that previous sample. A later read of that address returns it.
- R3: A low pulse on `we_n` while `cs_n` is high stores nothing. The addressed byte keeps its earlier value.
- R4: If the pins sampled at a clock edge show `cs_n` = 0, `oe_n` = 0 and `we_n` = 1, then `data_oe` is 1 after that edge.
- R5: If the pins sampled at an edge show `cs_n` = 1, or show `oe_n` and `we_n` both 1, then `data_oe` is 0 after that edge.
- R6: With `cs_n` = 0, a sample with `we_n` = 0 and `oe_n` = 0 is treated as a write. `data_oe` is 0 after that edge, and the write still commits when `we_n` rises.
- R7: A read starts at the first edge whose sample meets R4. `data_out` is 0 after that edge and after the next ACCESS_CYC-1 edges. After edge ACCESS_CYC it equals the addressed byte.
- R8: If `addr` changes while a read is held, the access delay of R7 restarts, counted from the edge that samples the new address.
- R9: `data_out` is 0 whenever `data_oe` is 0.
- R10: A selected write-enable low pulse must last at least WE_MIN_CYC (3) sampled cycles. A pulse of exactly that width is stored correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (11) | Byte address |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write commits on its rising edge |
| data_in | input | DATA_W (8) | Byte driven onto the data lane by the bus |
| data_out | output | DATA_W (8) | Byte the model drives when reading |
| data_oe | output | 1 | 1 when the model drives the data lane |

## Verification
Two cases are hard to reach from the ports. The first is a write that overlaps a read request: `oe_n` is held low through the whole write pulse. The bench has to see the driver stay off, see it turn on after `we_n` rises, and then see the new byte come out only after a full access delay. The second is an address change partway through a held read. The stimulus moves `addr` on a falling clock edge while `cs_n` and `oe_n` stay low, then expects zeros for ACCESS_CYC samples before the second byte appears. A write pulse with `cs_n` high is run against a byte written earlier, so that a stray store would show up in the readback.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int WE_MIN_CYC = 3;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
    } pin_ctrl_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

    localparam pin_ctrl_t CTRL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    // Truth table: deselect wins, then write, then read.
    function automatic bus_mode_e decode_mode(input pin_ctrl_t c);
        if (c.cs_n)       return BUS_IDLE;
        else if (!c.we_n) return BUS_WRITE;
        else if (!c.oe_n) return BUS_READ;
        else              return BUS_IDLE;
    endfunction

    function automatic int count_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
    import sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ctrl_t         raw_ctrl,
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [DATA_W-1:0] raw_din,
    output pin_ctrl_t         cur_ctrl,
    output logic [ADDR_W-1:0] cur_addr,
    output pin_ctrl_t         prv_ctrl,
    output logic [ADDR_W-1:0] prv_addr,
    output logic [DATA_W-1:0] prv_din
);

    logic [DATA_W-1:0] cur_din;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ctrl <= CTRL_IDLE;
            cur_addr <= '0;
            cur_din  <= '0;
            prv_ctrl <= CTRL_IDLE;
            prv_addr <= '0;
            prv_din  <= '0;
        end else begin
            cur_ctrl <= raw_ctrl;
            cur_addr <= raw_addr;
            cur_din  <= raw_din;
            prv_ctrl <= cur_ctrl;
            prv_addr <= cur_addr;
            prv_din  <= cur_din;
        end
    end

endmodule

// File: rtl/sram_access_timer.sv
module sram_access_timer
    import sram_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         raw_mode,
    input  logic [ADDR_W-1:0] raw_addr,
    input  bus_mode_e         cur_mode,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              data_ready
);

    localparam int CW = count_width(ACCESS_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(ACCESS_CYC);

    logic [CW-1:0] elapsed;
    logic          restart;

    // A read restarts when it begins or when its address moves.
    assign restart = (cur_mode != BUS_READ) || (raw_addr != cur_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (raw_mode != BUS_READ || restart) begin
            elapsed <= '0;
        end else if (elapsed < LIMIT) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign data_ready = (cur_mode == BUS_READ) && (elapsed >= LIMIT);

endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/async_sram_2kx8.sv
module async_sram_2kx8
    import sram_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    pin_ctrl_t         raw_ctrl;
    pin_ctrl_t         cur_ctrl;
    pin_ctrl_t         prv_ctrl;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] prv_addr;
    logic [DATA_W-1:0] prv_din;
    bus_mode_e         raw_mode;
    bus_mode_e         cur_mode;
    logic              wr_commit;
    logic              data_ready;
    logic [DATA_W-1:0] rd_data;

    assign raw_ctrl = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};
    assign raw_mode = decode_mode(raw_ctrl);
    assign cur_mode = decode_mode(cur_ctrl);

    sram_pin_sampler #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .raw_ctrl (raw_ctrl),
        .raw_addr (addr),
        .raw_din  (data_in),
        .cur_ctrl (cur_ctrl),
        .cur_addr (cur_addr),
        .prv_ctrl (prv_ctrl),
        .prv_addr (prv_addr),
        .prv_din  (prv_din)
    );

    // Commit on the low-to-high step of write enable seen between samples.
    assign wr_commit = (decode_mode(prv_ctrl) == BUS_WRITE) && cur_ctrl.we_n;

    sram_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_commit),
        .wr_addr (prv_addr),
        .wr_data (prv_din),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    sram_access_timer #(
        .ADDR_W     (ADDR_W),
        .ACCESS_CYC (ACCESS_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .raw_mode   (raw_mode),
        .raw_addr   (addr),
        .cur_mode   (cur_mode),
        .cur_addr   (cur_addr),
        .data_ready (data_ready)
    );

    assign data_oe  = (cur_mode == BUS_READ);
    assign data_out = (data_oe && data_ready) ? rd_data : '0;

endmodule

// File: rtl/sram_chk.sv
module sram_chk
    import sram_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 3,
    parameter int MIN_LOW    = WE_MIN_CYC
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe
);

    logic [7:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (!we_n && !cs_n) begin
            if (low_run != 8'hFF) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!data_oe && data_out == '0));                          // R1

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !oe_n && we_n) |=> data_oe);                          // R4

    AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (cs_n || (oe_n && we_n)) |=> !data_oe);                         // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> !data_oe);                                 // R6

    AST_QUIET_LANE: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_out == '0);                                   // R9

    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (we_n && low_run != '0) |-> low_run >= 8'(MIN_LOW));            // R10

    generate
        if (ACCESS_CYC > 0) begin : g_delay
            AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (rst)
                $rose(data_oe) |-> data_out == '0);                     // R7
        end
    endgenerate

endmodule

bind async_sram_2kx8 sram_chk #(
    .DATA_W     (DATA_W),
    .ACCESS_CYC (ACCESS_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .data_out (data_out),
    .data_oe  (data_oe)
);

// File: tb/tb_async_sram_2kx8.sv
module tb_async_sram_2kx8;

    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam int WMIN = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    async_sram_2kx8 #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC)) dut (
        .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sel_n);
        @(negedge clk);
        addr = a; data_in = d; cs_n = sel_n; oe_n = 1'b1; we_n = 1'b0;
        repeat (WMIN) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        data_in = ~d;
        repeat (2) @(negedge clk);
    endtask

    // Sets read pins (or a new address) and checks the full access window.
    task automatic read_window(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        for (int i = 0; i <= ACC; i++) begin
            @(negedge clk);
            check(data_oe == 1'b1, "R4", data_oe, 1);
            if (i < ACC) check(data_out == '0, "R7", data_out, 0);
            else         check(data_out == exp, req, data_out, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(data_oe == 1'b0 && data_out == '0, "R1", {data_oe, data_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(data_oe == 1'b0 && data_out == '0, "R1", {data_oe, data_out}, 0);
    endtask

    task automatic t_write_read();
        write_byte(11'h000, 8'hA5, 1'b0);
        write_byte(11'h7FF, 8'h5A, 1'b0);
        write_byte(11'h123, 8'hFF, 1'b0);
        write_byte(11'h124, 8'h00, 1'b0);
        read_window(11'h000, 8'hA5, "R2");
        go_idle();
        read_window(11'h7FF, 8'h5A, "R2");
        go_idle();
        read_window(11'h123, 8'hFF, "R2");
        go_idle();
        read_window(11'h124, 8'h00, "R2");
        go_idle();
    endtask

    task automatic t_deselected_pulse();
        write_byte(11'h005, 8'h11, 1'b0);
        write_byte(11'h005, 8'h99, 1'b1);
        read_window(11'h005, 8'h11, "R3");
        go_idle();
    endtask

    task automatic t_release();
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = 11'h000;
        repeat (2) @(negedge clk);
        check(data_oe == 1'b0, "R5", data_oe, 0);
        check(data_out == '0, "R9", data_out, 0);
        cs_n = 1'b0; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        check(data_oe == 1'b0, "R5", data_oe, 0);
        check(data_out == '0, "R9", data_out, 0);
        go_idle();
    endtask

    task automatic t_priority();
        @(negedge clk);
        addr = 11'h0C3; data_in = 8'h3C; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        for (int i = 0; i < WMIN; i++) begin
            @(negedge clk);
            check(data_oe == 1'b0, "R6", data_oe, 0);
        end
        we_n = 1'b1;
        for (int i = 0; i <= ACC; i++) begin
            @(negedge clk);
            check(data_oe == 1'b1, "R6", data_oe, 1);
            if (i == ACC) check(data_out == 8'h3C, "R6", data_out, 8'h3C);
        end
        go_idle();
    endtask

    task automatic t_addr_change();
        write_byte(11'h200, 8'h77, 1'b0);
        write_byte(11'h201, 8'h88, 1'b0);
        read_window(11'h200, 8'h77, "R8");
        read_window(11'h201, 8'h88, "R8");
        go_idle();
    endtask

    task automatic t_min_pulse();
        write_byte(11'h4AA, 8'hC7, 1'b0);
        read_window(11'h4AA, 8'hC7, "R10");
        go_idle();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_deselected_pulse();
        t_release();
        t_priority();
        t_addr_change();
        t_min_pulse();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule